// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a load/store core when control must leave the running program for a handler, and when it must come back. It does not push anything onto a memory stack. When an exception is taken, the old machine-state word is kept in one dedicated save register and the resume address in another. The live state word is then changed to supervisor mode, with external interrupts off and single-step off. A redirect pulse sends the fetch unit to the handler.

Each handler address is computed directly, with no table lookup. The cause code is multiplied by 256 to give an offset. A prefix bit in the state word chooses whether the upper address bits are all zero or 0xFFF00000. A return command puts the saved state word back and redirects fetch to the saved address.

The core writes the state word through a plain write strobe. The block itself raises two kinds of exception: maskable external interrupts, and single-step traps after each completed instruction.

Top module: `trap_seq_top`

## Requirements
- R1: After reset, msr is 0, redirect is 0 and next_pc is 0. Both save registers are also 0, so a return with no prior exception jumps to 0 and loads msr = 0.
- R2: On exception entry, the first save register captures the msr value from before the entry. The second save register captures cur_pc. Both become visible through a later return (see R8).
- R3: msr bit map: bit0 little-endian, bit1 vector prefix, bit2 single-step, bit3 user mode, bit4 external-interrupt enable, bit5 low-power. On entry, bits 2, 3 and 4 clear and bits 0, 1 and 5 keep their values.
- R4: One cycle after an entry, redirect is 1 for one cycle. next_pc is then cause×0x100 for causes 1 to 15. It is OR-ed with 0xFFF00000 when msr bit1 is 1, and has upper bits of zero when msr bit1 is 0.
- R5: A cause of 0 or of 16 to 31 uses the fallback offset 0x2000, with the same prefix rule as R4.
- R6: ext_irq is taken as an entry with cause 5 only while msr bit4 is 1. While bit4 is 0 it has no effect: redirect stays 0 and msr is unchanged.
- R7: insn_done while msr bit2 is 1 raises an entry with cause 13, which gives offset 0xD00.
- R8: On ret_req, msr is loaded from the first save register. One cycle later, redirect is 1 and next_pc equals the second save register.
- R9: Event priority, highest first: exc_req, ext_irq (enabled), single-step, ret_req, msr_wr. Only one event is taken per cycle. An exception in the same cycle as a return wins, and the return is dropped.
- R10: msr_wr loads msr_wdata into msr when no higher-priority event occurs in that cycle, and it causes no redirect.
- R11: In any cycle without an entry or a return, redirect is 0 in the following cycle and next_pc keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception strobe |
| exc_cause | input | 5 | Cause code for exc_req |
| ext_irq | input | 1 | External interrupt request, maskable |
| insn_done | input | 1 | An instruction completed this cycle |
| ret_req | input | 1 | Return-from-interrupt command |
| msr_wr | input | 1 | State-word write strobe |
| msr_wdata | input | 6 | State-word write value |
| cur_pc | input | 32 | Resume address to save on entry |
| redirect | output | 1 | next_pc is valid and must be fetched |
| next_pc | output | 32 | Handler or return target |
| msr | output | 6 | Live machine-state word |

## Verification
The bench targets events that collide in one cycle. An exception together with a return must enter the handler. A design that let the return win would jump back and restore the state instead. A masked ext_irq must leave msr and redirect untouched; a design that got this wrong would enter a cause-5 handler with interrupts off. Causes 0 and 16 to 31 must reach the 0x2000 fallback, where a plain shift would give a wrong or zero offset. The prefix bit must pick 0xFFF00000; an error here sends the handler to the wrong half of the address space. Back-to-back entry then return exposes a return that reads a stale save register, or restores the post-entry state word instead of the pre-entry one.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN  = 32;
  localparam int MSR_W = 6;

  localparam int B_LE  = 0;
  localparam int B_PFX = 1;
  localparam int B_SS  = 2;
  localparam int B_USR = 3;
  localparam int B_IE  = 4;
  localparam int B_PWR = 5;

  typedef logic [MSR_W-1:0] msr_t;
  typedef logic [XLEN-1:0]  addr_t;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_EXC  = 3'd1,
    EV_IRQ  = 3'd2,
    EV_STEP = 3'd3,
    EV_RET  = 3'd4,
    EV_WR   = 3'd5
  } ev_e;

  // State word after entry: supervisor, interrupts and stepping off.
  function automatic msr_t entry_msr(input msr_t m);
    msr_t r;
    r        = m;
    r[B_IE]  = 1'b0;
    r[B_SS]  = 1'b0;
    r[B_USR] = 1'b0;
    return r;
  endfunction

  // Offset for a cause: fixed spacing, fallback outside the table.
  function automatic addr_t cause_offset(input int unsigned cause,
                                         input int unsigned num_vec,
                                         input int unsigned shift,
                                         input addr_t       fallback);
    if (cause >= 1 && cause < num_vec)
      return addr_t'(cause) << shift;
    return fallback;
  endfunction

  // Prefix select on the upper address bits.
  function automatic addr_t vector_addr(input logic  pfx,
                                        input addr_t off,
                                        input addr_t hi);
    return pfx ? (hi | off) : off;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int CAUSE_W    = 5,
  parameter int STEP_CAUSE = 13,
  parameter int IRQ_CAUSE  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               ext_irq,
  input  logic               insn_done,
  input  logic               ret_req,
  input  logic               msr_wr,
  input  logic               msr_ie,
  input  logic               msr_ss,
  output ev_e                ev,
  output logic [CAUSE_W-1:0] ev_cause,
  output logic               take_entry,
  output logic               take_ret,
  output logic               take_wr
);
  logic irq_live;
  logic step_live;

  assign irq_live  = ext_irq && msr_ie;
  assign step_live = insn_done && msr_ss;

  always_comb begin
    ev       = EV_NONE;
    ev_cause = '0;
    if (exc_req) begin
      ev       = EV_EXC;
      ev_cause = exc_cause;
    end else if (irq_live) begin
      ev       = EV_IRQ;
      ev_cause = CAUSE_W'(IRQ_CAUSE);
    end else if (step_live) begin
      ev       = EV_STEP;
      ev_cause = CAUSE_W'(STEP_CAUSE);
    end else if (ret_req) begin
      ev = EV_RET;
    end else if (msr_wr) begin
      ev = EV_WR;
    end
  end

  assign take_entry = (ev == EV_EXC) || (ev == EV_IRQ) || (ev == EV_STEP);
  assign take_ret   = (ev == EV_RET);
  assign take_wr    = (ev == EV_WR);

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_entry, take_ret, take_wr})); // R9
  AST_EXC_BEATS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && ret_req) |-> (take_entry && !take_ret)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && !msr_ie && !exc_req && !step_live) |-> (ev != EV_IRQ)); // R6
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter msr_t MSR_RST = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_entry,
  input  logic  take_ret,
  input  logic  take_wr,
  input  msr_t  wdata,
  input  addr_t cur_pc,
  output msr_t  msr,
  output msr_t  srr_state,
  output addr_t srr_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr       <= MSR_RST;
      srr_state <= '0;
      srr_pc    <= '0;
    end else if (take_entry) begin
      srr_state <= msr;
      srr_pc    <= cur_pc;
      msr       <= entry_msr(msr);
    end else if (take_ret) begin
      msr <= srr_state;
    end else if (take_wr) begin
      msr <= wdata;
    end
  end

  AST_SAVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (srr_state == $past(msr))); // R2
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (srr_pc == $past(cur_pc))); // R2
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (!msr[B_IE] && !msr[B_SS] && !msr[B_USR])); // R3
  AST_ENTRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (msr[B_LE] == $past(msr[B_LE]) && msr[B_PFX] == $past(msr[B_PFX])
                    && msr[B_PWR] == $past(msr[B_PWR]))); // R3
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> (msr == $past(srr_state))); // R8
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_wr |=> (msr == $past(wdata))); // R10
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_entry && !take_ret && !take_wr) |=> $stable(msr)); // R11
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
  import trap_pkg::*;
#(
  parameter int    CAUSE_W  = 5,
  parameter int    NUM_VEC  = 16,
  parameter int    SPACE_SH = 8,
  parameter addr_t FALLBACK = 32'h0000_2000,
  parameter addr_t PFX_HI   = 32'hFFF0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_entry,
  input  logic               take_ret,
  input  logic [CAUSE_W-1:0] ev_cause,
  input  logic               pfx,
  input  addr_t              srr_pc,
  output logic               redirect,
  output addr_t              next_pc
);
  addr_t entry_off;
  addr_t entry_target;

  assign entry_off    = cause_offset(32'(ev_cause), NUM_VEC, SPACE_SH, FALLBACK);
  assign entry_target = vector_addr(pfx, entry_off, PFX_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect <= 1'b0;
      next_pc  <= '0;
    end else begin
      redirect <= take_entry || take_ret;
      if (take_entry)
        next_pc <= entry_target;
      else if (take_ret)
        next_pc <= srr_pc;
    end
  end

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (redirect && next_pc[SPACE_SH-1:0] == '0)); // R4
  AST_PREFIX_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_entry && pfx) |=> ((next_pc & PFX_HI) == PFX_HI)); // R4
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> (redirect && next_pc == $past(srr_pc))); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_entry && !take_ret) |=> (!redirect && $stable(next_pc))); // R11
endmodule

// File: rtl/trap_seq_top.sv
module trap_seq_top
  import trap_pkg::*;
#(
  parameter int    CAUSE_W    = 5,
  parameter int    NUM_VEC    = 16,
  parameter int    SPACE_SH   = 8,
  parameter int    STEP_CAUSE = 13,
  parameter int    IRQ_CAUSE  = 5,
  parameter addr_t FALLBACK   = 32'h0000_2000,
  parameter addr_t PFX_HI     = 32'hFFF0_0000,
  parameter msr_t  MSR_RST    = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               ext_irq,
  input  logic               insn_done,
  input  logic               ret_req,
  input  logic               msr_wr,
  input  logic [5:0]         msr_wdata,
  input  logic [31:0]        cur_pc,
  output logic               redirect,
  output logic [31:0]        next_pc,
  output logic [5:0]         msr
);
  ev_e                ev;
  logic [CAUSE_W-1:0] ev_cause;
  logic               take_entry;
  logic               take_ret;
  logic               take_wr;
  msr_t               srr_state;
  addr_t              srr_pc;

  trap_arbiter #(
    .CAUSE_W(CAUSE_W), .STEP_CAUSE(STEP_CAUSE), .IRQ_CAUSE(IRQ_CAUSE)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .exc_cause(exc_cause), .ext_irq(ext_irq),
    .insn_done(insn_done), .ret_req(ret_req), .msr_wr(msr_wr),
    .msr_ie(msr[B_IE]), .msr_ss(msr[B_SS]),
    .ev(ev), .ev_cause(ev_cause),
    .take_entry(take_entry), .take_ret(take_ret), .take_wr(take_wr)
  );

  trap_state_regs #(.MSR_RST(MSR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .take_entry(take_entry), .take_ret(take_ret), .take_wr(take_wr),
    .wdata(msr_wdata), .cur_pc(cur_pc),
    .msr(msr), .srr_state(srr_state), .srr_pc(srr_pc)
  );

  trap_redirect #(
    .CAUSE_W(CAUSE_W), .NUM_VEC(NUM_VEC), .SPACE_SH(SPACE_SH),
    .FALLBACK(FALLBACK), .PFX_HI(PFX_HI)
  ) u_redir (
    .clk(clk), .rst_n(rst_n),
    .take_entry(take_entry), .take_ret(take_ret),
    .ev_cause(ev_cause), .pfx(msr[B_PFX]), .srr_pc(srr_pc),
    .redirect(redirect), .next_pc(next_pc)
  );

  AST_STEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STEP) |=> (redirect && next_pc[15:0] == 16'h0D00)); // R7
endmodule

// File: tb/trap_seq_top_bench.sv
`timescale 1ns/1ps
module trap_seq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, ext_irq, insn_done, ret_req, msr_wr;
  logic [4:0]  exc_cause;
  logic [5:0]  msr_wdata;
  logic [31:0] cur_pc;
  logic        redirect;
  logic [31:0] next_pc;
  logic [5:0]  msr;

  int checks = 0;
  int fails  = 0;

  logic [5:0]  m_msr, m_srr1;
  logic [31:0] m_srr0, m_npc;
  logic        m_redir;

  always #2 clk = ~clk;

  trap_seq_top u_trap_seq_top (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .ext_irq(ext_irq), .insn_done(insn_done), .ret_req(ret_req),
    .msr_wr(msr_wr), .msr_wdata(msr_wdata), .cur_pc(cur_pc),
    .redirect(redirect), .next_pc(next_pc), .msr(msr)
  );

  function automatic logic [31:0] exp_target(input logic [5:0] st, input int c);
    logic [31:0] base;
    base = (c > 0 && c < 16) ? c * 256 : 32'h2000;
    return st[1] ? base + 32'hFFF0_0000 : base;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, advance the model, sample at the next falling edge.
  task automatic cyc(input logic e, input int c, input logic irq, input logic done,
                     input logic r, input logic w, input logic [5:0] wd,
                     input logic [31:0] pc);
    string tag;
    int    cause;
    logic  entry;
    exc_req = e; exc_cause = 5'(c); ext_irq = irq; insn_done = done;
    ret_req = r; msr_wr = w; msr_wdata = wd; cur_pc = pc;
    entry = 1'b1;
    cause = 0;
    if (e) begin
      cause = c;
      tag = (r) ? "R9" : ((c == 0 || c > 15) ? "R5" : "R4");
    end else if (irq && m_msr[4]) begin
      cause = 5; tag = "R6";
    end else if (done && m_msr[2]) begin
      cause = 13; tag = "R7";
    end else begin
      entry = 1'b0;
      tag = (irq) ? "R6" : (r ? "R2/R8" : (w ? "R10" : "R11"));
    end
    if (entry) begin
      m_srr1  = m_msr;
      m_srr0  = pc;
      m_npc   = exp_target(m_msr, cause);
      m_msr   = m_msr & 6'b100011;
      m_redir = 1'b1;
    end else if (r) begin
      m_msr   = m_srr1;
      m_npc   = m_srr0;
      m_redir = 1'b1;
    end else begin
      if (w) m_msr = wd;
      m_redir = 1'b0;
    end
    @(negedge clk);
    check({tag, " redirect"}, 32'(redirect), 32'(m_redir));
    check({tag, " next_pc"}, next_pc, m_npc);
    check({tag, (entry ? " msr R3" : " msr")}, 32'(msr), 32'(m_msr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    exc_req = 0; ext_irq = 0; insn_done = 0; ret_req = 0; msr_wr = 0;
    exc_cause = 0; msr_wdata = 0; cur_pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_msr = 0; m_srr1 = 0; m_srr0 = 0; m_npc = 0; m_redir = 0;
    // R1 reset state
    check("R1 msr", 32'(msr), 0);
    check("R1 redirect", 32'(redirect), 0);
    check("R1 next_pc", next_pc, 0);
    // R1 return with nothing saved
    cyc(0, 0, 0, 0, 1, 0, 0, 32'h40);
    // R10 write prefix bit, then R4 prefixed entry and R8 return
    cyc(0, 0, 0, 0, 0, 1, 6'b000010, 0);
    cyc(1, 5, 0, 0, 0, 0, 0, 32'h0000_1000);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    // R6 enabled interrupt, then masked interrupt
    cyc(0, 0, 0, 0, 0, 1, 6'b011101, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 32'h0000_2224);
    cyc(0, 0, 1, 0, 0, 0, 0, 32'h0000_2228);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 fallback causes
    cyc(1, 0, 0, 0, 0, 0, 0, 32'h300);
    cyc(1, 20, 0, 0, 0, 0, 0, 32'h304);
    cyc(1, 31, 0, 0, 0, 0, 0, 32'h308);
    cyc(1, 15, 0, 0, 0, 0, 0, 32'h30C);
    // R7 single step
    cyc(0, 0, 0, 0, 0, 1, 6'b000100, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 32'h0000_0500);
    cyc(0, 0, 0, 1, 0, 0, 0, 32'h0000_0504);
    // R2/R8 return restores pre-entry state
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    // R9 exception beats return; return beats write
    cyc(1, 3, 0, 0, 1, 0, 0, 32'h0000_0800);
    cyc(0, 0, 0, 0, 1, 1, 6'b111111, 0);
    // Random traffic
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 100) < 12, int'($urandom % 32), ($urandom % 100) < 20,
          ($urandom % 100) < 40, ($urandom % 100) < 15, ($urandom % 100) < 12,
          6'($urandom), {$urandom, 2'b00} & 32'hFFFF_FFFC);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule